// File: doc/BRIEF.md
# Per-Lane Deskew Aligner with Phase Tracking

This block sits behind the receive capture flops of a byte-wide source-synchronous link. The link has nine lanes: eight data lanes and one lane that carries tag and parity. Each lane is captured on both edges of a forwarded half-rate clock. The skew from one lane to another can be larger than a whole bit period, so the capture clock alone cannot give a coherent word. The aligner fixes this one lane at a time. Each lane runs through its own eight-stage shift register, and a tap selector on that register sets the lane's coarse delay of 0 to 7 bit-times. The analog delay line is represented only by a fine phase code for each lane, which this block computes and drives out.

During initialisation the far end sends a continuous stream of all-zero words. Now and then it inserts a word in which all nine lanes are 1. A controller finds the first such word and notes how many bit-times each lane's 1 arrives after the earliest lane's 1. It then delays every lane so that all nine 1s fall in the same bit-time. The controller then waits for more training words that arrive whole. After enough of them it raises a locked flag. While locked, every lane has a bang-bang phase detector fed by an edge sample taken between data samples. The detector steps that lane's fine phase code up or down to keep the data sample centred in the eye.

The controller has five states:
- HUNT waits for any raw lane to show a 1.
- COLLECT records the arrival offsets over an eight bit-time window.
- APPLY loads the taps, or returns to HUNT if a lane never showed a 1.
- VERIFY counts whole all-ones words, returns to HUNT on a split word, and goes to LOCKED after the third whole word.
- LOCKED holds, with fine tracking enabled.

A retrain request sends the controller from any state back to HUNT.

Top module: `deskew_aligner`

## Requirements
- R1: Synchronous active-high reset clears all coarse taps to 0, `word_o` to zero and `locked_o` to 0, and sets every lane's fine phase code to the midpoint 4 (3-bit code).
- R2: On the first training word, every lane's tap is set to (latest arrival offset − that lane's arrival offset). A training word has bit 1 on all nine lanes, lane 8 being tag/parity. Offsets are counted in bit-times from the earliest lane's 1, with a total spread of at most 7. Afterwards any word sent over the skewed link appears whole on `word_o` in exactly one cycle, and the taps change only when APPLY loads them.
- R3: After coarse alignment, `locked_o` rises only when three consecutive training words arrive whole. It stays low after two.
- R4: In VERIFY, an aligned word that is nonzero but not all ones discards the count and returns to HUNT. The next training word redoes the coarse alignment, and three further whole training words are again needed to lock.
- R5: If any lane fails to show a 1 within the eight bit-times that start at the earliest lane's 1, the taps are not loaded and hunting resumes, so a dead lane never allows lock.
- R6: A retrain request drops `locked_o` on the next cycle and returns to HUNT. `locked_o` stays low until a new full training sequence completes.
- R7: While locked, a transition on a lane counts as early when that lane's edge sample `rx_edge_i` equals the previous data bit. `rx_edge_i` is taken half a bit-time before the same cycle's `rx_data_i`. The eighth early count raises that lane's phase code by 1 and clears both of its counters. Fewer counts change nothing.
- R8: While locked, a transition whose edge sample equals the new data bit counts as late. The eighth late count lowers the phase code by 1 and clears both counters.
- R9: The phase code saturates at 0 and 7 and never moves by more than 1 in one cycle.
- R10: While not locked, the detector counters are held clear and no phase code changes, whatever the lane transitions are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock (one data and one edge sample per lane per cycle) |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_data_i | input | 9 | Data samples, one per lane; bit 8 is the tag/parity lane |
| rx_edge_i | input | 9 | Edge samples, taken half a bit-time before each data sample |
| retrain_i | input | 1 | Request to drop lock and restart the training hunt |
| word_o | output | 9 | Lane-aligned word, registered |
| locked_o | output | 1 | Alignment achieved and fine tracking active |
| fine_phase_o | output | 27 | Fine phase codes, 3 bits per lane, lane 0 in bits 2:0 |

## Verification
The hardest condition to reach is a training word that splits after coarse alignment has already succeeded. The bench's skew model delays each lane by a programmable number of whole words. It changes one lane's skew by a single bit-time between the coarse-alignment word and the first verify word, which makes the controller see eight lanes set and one clear. The fine detector is hard to drive in exact counts, because ordinary traffic also produces transitions. The bench therefore overrides lane 0 alone with even-length toggle bursts that end on 0, and sets each edge sample from the data bit before or after it. This gives an exact number of early or late events with no stray event at the end of the burst.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    // Alignment controller states
    typedef enum logic [2:0] {
        S_HUNT    = 3'd0,
        S_COLLECT = 3'd1,
        S_APPLY   = 3'd2,
        S_VERIFY  = 3'd3,
        S_LOCKED  = 3'd4
    } align_state_e;

endpackage

// File: rtl/lane_delay.sv
module lane_delay #(
    parameter int DEPTH = 8,
    localparam int TW = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          din_i,
    input  logic [TW-1:0] tap_i,
    output logic          raw_o,
    output logic          sel_o
);
    logic [DEPTH-1:0] hist_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= {hist_q[DEPTH-2:0], din_i};
    end

    assign raw_o = hist_q[0];
    assign sel_o = hist_q[tap_i];
endmodule

// File: rtl/phase_tracker.sv
module phase_tracker #(
    parameter int PD_LIMIT = 8,
    parameter int PH_W     = 3,
    localparam int CW = $clog2(PD_LIMIT)
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            en_i,
    input  logic            d_prev_i,
    input  logic            d_cur_i,
    input  logic            e_cur_i,
    output logic [PH_W-1:0] phase_o
);
    localparam logic [PH_W-1:0] PH_MID = PH_W'(1 << (PH_W - 1));
    localparam logic [PH_W-1:0] PH_MAX = '1;
    localparam logic [CW-1:0]   CNT_TOP = CW'(PD_LIMIT - 1);

    logic [CW-1:0] early_q, late_q;
    logic          trans, is_early, is_late;

    assign trans    = d_prev_i ^ d_cur_i;
    assign is_early = trans && (e_cur_i == d_prev_i);
    assign is_late  = trans && (e_cur_i == d_cur_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            early_q <= '0;
            late_q  <= '0;
            phase_o <= PH_MID;
        end else if (!en_i) begin
            early_q <= '0;
            late_q  <= '0;
        end else if (is_early) begin
            if (early_q == CNT_TOP) begin
                early_q <= '0;
                late_q  <= '0;
                if (phase_o != PH_MAX) phase_o <= phase_o + 1'b1;
            end else begin
                early_q <= early_q + 1'b1;
            end
        end else if (is_late) begin
            if (late_q == CNT_TOP) begin
                early_q <= '0;
                late_q  <= '0;
                if (phase_o != '0) phase_o <= phase_o - 1'b1;
            end else begin
                late_q <= late_q + 1'b1;
            end
        end
    end

    // R7 R8 R9
    phase_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (phase_o == $past(phase_o)) ||
                 ({1'b0, phase_o} == {1'b0, $past(phase_o)} + 1'b1) ||
                 ({1'b0, $past(phase_o)} == {1'b0, phase_o} + 1'b1));

    // R10
    frozen_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(phase_o));
endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
    import deskew_pkg::*;
#(
    parameter int LANES      = 9,
    parameter int DLY_TAPS   = 8,
    parameter int LOCK_WORDS = 3,
    localparam int TW = $clog2(DLY_TAPS),
    localparam int GW = $clog2(LOCK_WORDS + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  retrain_i,
    input  logic [LANES-1:0]      raw_i,
    input  logic [LANES-1:0]      aligned_i,
    output logic [LANES*TW-1:0]   taps_o,
    output logic                  track_en_o,
    output logic                  locked_o
);
    align_state_e   state, state_n;
    logic [TW-1:0]  win_q;
    logic [LANES-1:0] seen_q;
    logic [TW-1:0]  arr_q [LANES];
    logic [GW-1:0]  good_q;
    logic [TW-1:0]  max_arr;
    logic           all_ones, any_one, all_seen;

    assign all_ones = &aligned_i;
    assign any_one  = |aligned_i;
    assign all_seen = &seen_q;

    always_comb begin
        max_arr = '0;
        for (int i = 0; i < LANES; i++)
            if (arr_q[i] > max_arr) max_arr = arr_q[i];
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_HUNT:    if (|raw_i) state_n = S_COLLECT;
            S_COLLECT: if (win_q == TW'(DLY_TAPS - 1)) state_n = S_APPLY;
            S_APPLY:   state_n = all_seen ? S_VERIFY : S_HUNT;
            S_VERIFY: begin
                if (all_ones) begin
                    if (good_q == GW'(LOCK_WORDS - 1)) state_n = S_LOCKED;
                end else if (any_one) begin
                    state_n = S_HUNT;
                end
            end
            S_LOCKED:  state_n = S_LOCKED;
            default:   state_n = S_HUNT;
        endcase
        if (retrain_i) state_n = S_HUNT;
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state <= S_HUNT;
        else       state <= state_n;
    end

    // arrival capture, tap load, verify count
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            win_q  <= '0;
            seen_q <= '0;
            good_q <= '0;
            taps_o <= '0;
            for (int i = 0; i < LANES; i++) arr_q[i] <= '0;
        end else begin
            unique case (state)
                S_HUNT: begin
                    win_q  <= TW'(1);
                    seen_q <= raw_i;
                    for (int i = 0; i < LANES; i++) arr_q[i] <= '0;
                end
                S_COLLECT: begin
                    win_q <= win_q + 1'b1;
                    for (int i = 0; i < LANES; i++)
                        if (raw_i[i] && !seen_q[i]) begin
                            seen_q[i] <= 1'b1;
                            arr_q[i]  <= win_q;
                        end
                end
                S_APPLY: begin
                    good_q <= '0;
                    if (all_seen)
                        for (int i = 0; i < LANES; i++)
                            taps_o[i*TW +: TW] <= max_arr - arr_q[i];
                end
                S_VERIFY: if (all_ones) good_q <= good_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) locked_o <= 1'b0;
        else       locked_o <= (state_n == S_LOCKED);
    end

    assign track_en_o = (state == S_LOCKED);

    // R3
    lock_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(locked_o) |-> ($past(state) == S_VERIFY));

    // R6
    retrain_unlock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        retrain_i |=> !locked_o);

    // R2
    tap_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state != S_APPLY) |=> $stable(taps_o));
endmodule

// File: rtl/deskew_aligner.sv
module deskew_aligner #(
    parameter int LANES      = 9,
    parameter int DLY_TAPS   = 8,
    parameter int PD_LIMIT   = 8,
    parameter int PH_W       = 3,
    parameter int LOCK_WORDS = 3,
    localparam int TW = $clog2(DLY_TAPS)
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [LANES-1:0]      rx_data_i,
    input  logic [LANES-1:0]      rx_edge_i,
    input  logic                  retrain_i,
    output logic [LANES-1:0]      word_o,
    output logic                  locked_o,
    output logic [LANES*PH_W-1:0] fine_phase_o
);
    logic [LANES-1:0]    raw_bits, sel_bits;
    logic [LANES*TW-1:0] taps;
    logic                track_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_delay #(.DEPTH(DLY_TAPS)) u_dly (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .din_i (rx_data_i[g]),
            .tap_i (taps[g*TW +: TW]),
            .raw_o (raw_bits[g]),
            .sel_o (sel_bits[g])
        );
        phase_tracker #(.PD_LIMIT(PD_LIMIT), .PH_W(PH_W)) u_pd (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .en_i     (track_en),
            .d_prev_i (raw_bits[g]),
            .d_cur_i  (rx_data_i[g]),
            .e_cur_i  (rx_edge_i[g]),
            .phase_o  (fine_phase_o[g*PH_W +: PH_W])
        );
    end

    align_ctrl #(
        .LANES(LANES), .DLY_TAPS(DLY_TAPS), .LOCK_WORDS(LOCK_WORDS)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .retrain_i  (retrain_i),
        .raw_i      (raw_bits),
        .aligned_i  (sel_bits),
        .taps_o     (taps),
        .track_en_o (track_en),
        .locked_o   (locked_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) word_o <= '0;
        else       word_o <= sel_bits;
    end

    // R1
    reset_chk: assert property (@(posedge clk_i)
        rst_i |=> (word_o == '0) && !locked_o);
endmodule

// File: tb/deskew_aligner_bench.sv
module deskew_aligner_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  rx_data = '0;
    logic [8:0]  rx_edge = '0;
    logic        retrain = 1'b0;
    logic [8:0]  word;
    logic        locked;
    logic [26:0] phases;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    int         skew [9];
    logic [8:0] hist [16];
    logic [8:0] kill = '0;
    bit         ovr0 = 1'b0;
    logic       ovr_d = 1'b0;
    logic       ovr_e = 1'b0;
    logic       rt = 1'b0;
    int         exp_ph = 4;

    always #5 clk = ~clk;

    deskew_aligner u_deskew_aligner (
        .clk_i        (clk),
        .rst_i        (rst),
        .rx_data_i    (rx_data),
        .rx_edge_i    (rx_edge),
        .retrain_i    (retrain),
        .word_o       (word),
        .locked_o     (locked),
        .fine_phase_o (phases)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one bit-time: push the ideal word and drive each lane with its own skew
    task automatic tick(input logic [8:0] w);
        logic [8:0] d;
        @(negedge clk);
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = w;
        for (int i = 0; i < 9; i++) d[i] = hist[skew[i]][i] & ~kill[i];
        rx_data = d;
        rx_edge = d;
        if (ovr0) begin
            rx_data[0] = ovr_d;
            rx_edge[0] = ovr_e;
        end
        retrain = rt;
    endtask

    task automatic train_word();
        tick(9'h1FF);
        repeat (15) tick(9'h000);
    endtask

    // even-length toggle burst on lane 0 ending at 0
    task automatic burst(input int n, input bit early);
        logic prev = 1'b0;
        ovr0 = 1'b1;
        for (int i = 1; i <= n; i++) begin
            ovr_d = logic'(i % 2);
            ovr_e = early ? prev : ovr_d;
            tick(9'h000);
            prev = ovr_d;
        end
        ovr_d = 1'b0;
        ovr_e = 1'b0;
        repeat (3) tick(9'h000);
        ovr0 = 1'b0;
    endtask

    task automatic test_reset();
        chk(word == 9'h000, "R1 word", word, 0);
        chk(locked == 1'b0, "R1 locked", locked, 0);
        for (int i = 0; i < 9; i++)
            chk(phases[i*3 +: 3] == 3'd4, "R1 phase", phases[i*3 +: 3], 4);
    endtask

    task automatic test_dead_lane();
        kill = 9'h008;
        repeat (5) train_word();
        chk(locked == 1'b0, "R5 dead lane no lock", locked, 0);
        kill = '0;
    endtask

    task automatic test_lock();
        repeat (3) train_word();
        chk(locked == 1'b0, "R3 not after two", locked, 0);
        train_word();
        chk(locked == 1'b1, "R3 lock after three", locked, 1);
    endtask

    task automatic scan_word(input logic [8:0] pat);
        int nz = 0;
        int hit = 0;
        tick(pat);
        for (int c = 0; c < 20; c++) begin
            tick(9'h000);
            if (word != 9'h000) begin
                nz++;
                if (word == pat) hit++;
            end
        end
        chk(nz == 1 && hit == 1, "R2 whole word", nz * 16 + hit, 17);
    endtask

    task automatic test_retrain();
        rt = 1'b1;
        tick(9'h000);
        rt = 1'b0;
        tick(9'h000);
        chk(locked == 1'b0, "R6 unlock next cycle", locked, 1'b0);
        repeat (20) tick(9'h000);
        chk(locked == 1'b0, "R6 stays unlocked", locked, 1'b0);
    endtask

    task automatic test_untracked();
        burst(8, 1'b1);
        chk(int'(phases[2:0]) == exp_ph, "R10 phase frozen", phases[2:0], exp_ph);
    endtask

    task automatic test_misalign();
        train_word();
        skew[2] = 6;
        train_word();
        chk(locked == 1'b0, "R4 split word", locked, 0);
        repeat (3) train_word();
        chk(locked == 1'b0, "R4 count restarted", locked, 0);
        train_word();
        chk(locked == 1'b1, "R4 relock", locked, 1);
    endtask

    task automatic test_tracking();
        burst(6, 1'b1);
        chk(int'(phases[2:0]) == 4, "R7 six early no step", phases[2:0], 4);
        burst(2, 1'b1);
        chk(int'(phases[2:0]) == 5, "R7 eighth early steps", phases[2:0], 5);
        burst(8, 1'b0);
        chk(int'(phases[2:0]) == 4, "R8 late steps", phases[2:0], 4);
        burst(32, 1'b0);
        chk(int'(phases[2:0]) == 0, "R8 down to zero", phases[2:0], 0);
        burst(8, 1'b0);
        chk(int'(phases[2:0]) == 0, "R9 floor", phases[2:0], 0);
        burst(56, 1'b1);
        chk(int'(phases[2:0]) == 7, "R9 up to top", phases[2:0], 7);
        burst(8, 1'b1);
        chk(int'(phases[2:0]) == 7, "R9 ceiling", phases[2:0], 7);
        chk(phases[5:3] == 3'd4, "R7 other lane untouched", phases[5:3], 4);
        chk(locked == 1'b1, "R7 lock kept", locked, 1);
    endtask

    initial begin
        skew[0] = 2; skew[1] = 0; skew[2] = 5; skew[3] = 1; skew[4] = 7;
        skew[5] = 3; skew[6] = 4; skew[7] = 6; skew[8] = 2;
        for (int k = 0; k < 16; k++) hist[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_dead_lane();
        test_lock();
        scan_word(9'h1A5);
        scan_word(9'h05A);
        scan_word(9'h100);
        test_retrain();
        test_untracked();
        test_misalign();
        test_tracking();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end
endmodule